// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the digital core of a synchronous buck power stage. A three-level PWM command arrives already decoded into a 2-bit code. From it the block derives the enables for the high-side and low-side gates. It enforces break-before-make spacing between the two gates, counted in clock cycles.

In the mid or floating state the high-side gate is turned off, but the low-side gate is not dropped at once. It keeps conducting until a zero-current comparator reports that the inductor current has reached zero. From then on both gates stay off until the command returns to a definite high or low.

Four conditions override the command:
- A low-side enable that is held low keeps the low-side gate off, which gives discontinuous conduction.
- A global enable that is low stops all pulse generation.
- A fault input from the supply or thermal supervisor forces both gates off.
- After reset, or when any blocking condition ends, a new command must be sampled before either gate is driven.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, both gate outputs are 0.
- R2: Command code 2'b01 (high) turns the high-side gate on and the low-side gate off. The high-side gate rises on the second clock edge after the code is presented, provided the dead time has already elapsed.
- R3: Command code 2'b00 (low) with the low-side enable at 1 turns the low-side gate on and the high-side gate off, with the same latency as R2.
- R4: Command codes 2'b10 (mid) and 2'b11 (open) turn the high-side gate off. The low-side gate is kept on, or turned on, while the low-side enable is 1 and no zero current has been seen. It drops on the first edge at which zc_i is sampled high while the sampled code is mid or open.
- R5: Once zero current has been seen in the mid or open state, the low-side gate stays off even after zc_i returns to 0. This lasts until the sampled command is high or low again.
- R6: With the low-side enable at 0, the low-side gate is off from the next edge onward, whatever the command. The high-side gate is unaffected.
- R7: With the global enable at 0, both gates are off from the next edge onward. Command changes during that time have no effect.
- R8: With the fault input at 1, both gates are off from the next edge onward.
- R9: After either gate falls, both gates stay off for max(N,1) whole cycles, where N is the dead-time input, before any gate rises. When a gate is requested, it rises exactly at the end of that gap.
- R10: The two gates are never on in the same cycle.
- R11: After reset, or after the global enable returns to 1 and the fault input to 0, no gate rises before the second clock edge following the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl_i | input | 2 | Decoded command: 00 low, 01 high, 10 mid, 11 open |
| zc_i | input | 1 | Zero inductor current indication |
| en_i | input | 1 | Global enable; 0 stops pulse generation |
| ls_en_i | input | 1 | Low-side enable; 0 keeps the low-side gate off |
| flt_i | input | 1 | Supply or thermal fault; 1 forces both gates off |
| dead_cyc_i | input | DT_W | Dead time N in clock cycles |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
A zero-current latch that is stuck set or left uncleared shows at the ports as a low-side gate that stays off, or comes back on, two edges after a valid low or high command. A dead-time counter that counts wrongly moves the rising edge of the next gate by one or more cycles, so an exact per-cycle comparison against a reference model catches it on the first transition. A sample-valid flag that is cleared late lets a gate rise on the first edge after a block is released, one cycle earlier than allowed.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [1:0] {
    LVL_LO   = 2'b00,
    LVL_HI   = 2'b01,
    LVL_MID  = 2'b10,
    LVL_OPEN = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    DRV_OFF = 2'b00,
    DRV_HS  = 2'b01,
    DRV_LS  = 2'b10
  } drv_e;

  // A definite level is low or high; mid and open are both tri-state.
  function automatic logic lvl_definite(input logic [1:0] lvl);
    return (lvl == LVL_LO) || (lvl == LVL_HI);
  endfunction

  // Gap satisfied when the cycles already spent off, plus the current one,
  // reach the programmed dead time (zero behaves as one).
  function automatic logic gap_met(input logic [15:0] idle_cnt,
                                   input logic [15:0] dead_cfg);
    logic [16:0] done_cyc;
    done_cyc = {1'b0, idle_cnt} + 17'd1;
    return done_cyc >= {1'b0, dead_cfg};
  endfunction

endpackage

// File: rtl/hb_pwm_sample.sv
module hb_pwm_sample
  import hb_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl_i,
  input  logic       blk_i,
  output logic [1:0] lvl_q_o,
  output logic       vld_o
);

  logic [1:0] lvl_q;
  logic       vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_OPEN;
      vld_q <= 1'b0;
    end else begin
      lvl_q <= pwm_lvl_i;
      vld_q <= !blk_i;
    end
  end

  assign lvl_q_o = lvl_q;
  assign vld_o   = vld_q;

  a_r11_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
    blk_i |=> !vld_q);

endmodule

// File: rtl/hb_zcd_latch.sv
module hb_zcd_latch
  import hb_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_q_i,
  input  logic       zc_i,
  input  logic       blk_i,
  output logic       zc_seen_o,
  output logic       zc_now_o
);

  logic zc_lat;
  logic in_mid;

  assign in_mid   = !lvl_definite(lvl_q_i);
  assign zc_now_o = in_mid && (zc_lat || zc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_lat <= 1'b0;
    end else if (blk_i || !in_mid) begin
      zc_lat <= 1'b0;
    end else if (zc_i) begin
      zc_lat <= 1'b1;
    end
  end

  assign zc_seen_o = zc_lat;

  a_r5_zc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_lat && in_mid && !blk_i) |=> zc_lat);

endmodule

// File: rtl/hb_target_dec.sv
module hb_target_dec
  import hb_gate_pkg::*;
(
  input  logic [1:0] lvl_q_i,
  input  logic       vld_i,
  input  logic       blk_i,
  input  logic       ls_en_i,
  input  logic       zc_now_i,
  output drv_e       tgt_o
);

  always_comb begin
    tgt_o = DRV_OFF;
    if (!blk_i && vld_i) begin
      unique case (lvl_q_i)
        LVL_HI:  tgt_o = DRV_HS;
        LVL_LO:  tgt_o = ls_en_i ? DRV_LS : DRV_OFF;
        default: tgt_o = (ls_en_i && !zc_now_i) ? DRV_LS : DRV_OFF;
      endcase
    end
  end

endmodule

// File: rtl/hb_dead_seq.sv
module hb_dead_seq
  import hb_gate_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  drv_e            tgt_i,
  input  logic [DT_W-1:0] dead_cyc_i,
  output logic            hs_o,
  output logic            ls_o
);

  localparam logic [DT_W-1:0] CNT_SAT = {DT_W{1'b1}};

  logic            hs_q, ls_q;
  logic            hs_nxt, ls_nxt;
  logic [DT_W-1:0] idle_cnt;
  logic            gap_ok;
  logic            fall_evt;

  assign gap_ok = gap_met(16'(idle_cnt), 16'(dead_cyc_i));

  always_comb begin
    hs_nxt = (tgt_i == DRV_HS) && !ls_q && (hs_q || gap_ok);
    ls_nxt = (tgt_i == DRV_LS) && !hs_q && (ls_q || gap_ok);
  end

  assign fall_evt = (hs_q && !hs_nxt) || (ls_q && !ls_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q     <= 1'b0;
      ls_q     <= 1'b0;
      idle_cnt <= CNT_SAT;
    end else begin
      hs_q <= hs_nxt;
      ls_q <= ls_nxt;
      if (fall_evt)
        idle_cnt <= '0;
      else if (idle_cnt != CNT_SAT)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  a_r9_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(!hs_q && !ls_q));

  a_r9_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> $past(!hs_q && !ls_q));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pwm_lvl_i,
  input  logic            zc_i,
  input  logic            en_i,
  input  logic            ls_en_i,
  input  logic            flt_i,
  input  logic [DT_W-1:0] dead_cyc_i,
  output logic            hs_gate_o,
  output logic            ls_gate_o
);

  logic       blk;
  logic [1:0] lvl_q;
  logic       vld;
  logic       zc_seen;
  logic       zc_now;
  drv_e       tgt;

  assign blk = !en_i || flt_i;

  hb_pwm_sample u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_lvl_i (pwm_lvl_i),
    .blk_i     (blk),
    .lvl_q_o   (lvl_q),
    .vld_o     (vld)
  );

  hb_zcd_latch u_zcd (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_q_i   (lvl_q),
    .zc_i      (zc_i),
    .blk_i     (blk),
    .zc_seen_o (zc_seen),
    .zc_now_o  (zc_now)
  );

  hb_target_dec u_dec (
    .lvl_q_i  (lvl_q),
    .vld_i    (vld),
    .blk_i    (blk),
    .ls_en_i  (ls_en_i),
    .zc_now_i (zc_now),
    .tgt_o    (tgt)
  );

  hb_dead_seq #(.DT_W(DT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt_i      (tgt),
    .dead_cyc_i (dead_cyc_i),
    .hs_o       (hs_gate_o),
    .ls_o       (ls_gate_o)
  );

  a_r7_en_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!hs_gate_o && !ls_gate_o));

  a_r8_flt_off: assert property (@(posedge clk) disable iff (!rst_n)
    flt_i |=> (!hs_gate_o && !ls_gate_o));

  a_r6_ls_block: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_en_i |=> !ls_gate_o);

  a_r5_no_ls_after_zc: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_seen && !lvl_definite(lvl_q)) |=> !$rose(ls_gate_o));

  a_r11_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate_o) || $rose(ls_gate_o)) |-> $past(vld));

endmodule

// File: tb/hb_gate_ctrl_tb.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb;

  localparam int DT_W = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      pwm = 2'b11;
  logic            zc = 1'b0, en = 1'b1, ls_en = 1'b1, flt = 1'b0;
  logic [DT_W-1:0] dead = 6'd3;
  logic            hs, ls;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_ctrl #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_lvl_i(pwm), .zc_i(zc), .en_i(en),
    .ls_en_i(ls_en), .flt_i(flt), .dead_cyc_i(dead),
    .hs_gate_o(hs), .ls_gate_o(ls)
  );

  // Reference model: 0 = none, 1 = high side, 2 = low side.
  logic [1:0] m_lvl;
  bit         m_vld, m_zc, m_hs, m_ls;
  int         m_idle;

  function automatic int want(input logic [1:0] lv, input bit v, input bit zl);
    bit block;
    block = !en || flt;
    if (block || !v) return 0;
    if (lv == 2'b01) return 1;
    if (lv == 2'b00) return ls_en ? 2 : 0;
    return (ls_en && !(zl || zc)) ? 2 : 0;
  endfunction

  function automatic bit gap_done(input int idle, input int n);
    int need;
    need = (n < 1) ? 1 : n;
    return (idle + 1) >= need;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl <= 2'b11; m_vld <= 0; m_zc <= 0; m_hs <= 0; m_ls <= 0; m_idle <= 1000;
    end else begin
      int  w;
      bit  nh, nl;
      w  = want(m_lvl, m_vld, m_zc);
      nh = (w == 1) && !m_ls && (m_hs || gap_done(m_idle, int'(dead)));
      nl = (w == 2) && !m_hs && (m_ls || gap_done(m_idle, int'(dead)));
      m_idle <= ((m_hs && !nh) || (m_ls && !nl)) ? 0 : m_idle + 1;
      m_hs <= nh;
      m_ls <= nl;
      m_zc <= (!en || flt || pwm_is_def(m_lvl)) ? 1'b0 : (m_zc | zc);
      m_vld <= !(!en || flt);
      m_lvl <= pwm;
    end
  end

  function automatic bit pwm_is_def(input logic [1:0] lv);
    return lv[1] == 1'b0;
  endfunction

  // Continuous comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (hs !== m_hs || ls !== m_ls) begin
        fails++;
        $display("FAIL R10 model mismatch t=%0t hs/ls=%b%b expected %b%b",
                 $time, hs, ls, m_hs, m_ls);
      end
      checks++;
      if (hs && ls) begin
        fails++;
        $display("FAIL R10 both gates on actual=11 expected not 11");
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit eh, input bit el, input string req);
    #0.1;
    checks++;
    if (hs !== eh || ls !== el) begin
      fails++;
      $display("FAIL %s hs/ls actual=%b%b expected=%b%b t=%0t", req, hs, ls, eh, el, $time);
    end
  endtask

  initial begin : wdog
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    pwm = 2'b00;
    cyc(3);
    chk(0, 0, "R1 in reset");
    rst_n = 1'b1;
    cyc(1); chk(0, 0, "R1 first cycle");
    cyc(1); chk(0, 1, "R3 low on");
    // high with dead time 3
    pwm = 2'b01;
    cyc(1); chk(0, 1, "R2 sample latency");
    cyc(1); chk(0, 0, "R9 low falls");
    cyc(2); chk(0, 0, "R9 gap held");
    cyc(1); chk(1, 0, "R2 high on after gap");
    // mid state
    pwm = 2'b10;
    cyc(2); chk(0, 0, "R4 high off in mid");
    cyc(3); chk(0, 1, "R4 low on in mid");
    zc = 1'b1;
    cyc(1); chk(0, 0, "R4 zero current drops low");
    zc = 1'b0;
    cyc(6); chk(0, 0, "R5 stays off");
    pwm = 2'b00;
    cyc(2); chk(0, 1, "R5 cleared by low");
    // low-side enable
    ls_en = 1'b0;
    cyc(1); chk(0, 0, "R6 low forced off");
    cyc(3); chk(0, 0, "R6 held off");
    ls_en = 1'b1;
    cyc(1); chk(0, 1, "R6 released");
    // global enable
    en = 1'b0;
    cyc(1); chk(0, 0, "R7 disable");
    pwm = 2'b01;
    cyc(5); chk(0, 0, "R7 command ignored");
    en = 1'b1;
    cyc(1); chk(0, 0, "R11 fresh sample wait");
    cyc(1); chk(1, 0, "R11 first gate");
    // fault
    flt = 1'b1;
    cyc(1); chk(0, 0, "R8 fault off");
    cyc(3); chk(0, 0, "R8 fault held");
    flt = 1'b0;
    cyc(1); chk(0, 0, "R11 after fault");
    cyc(1); chk(1, 0, "R11 after fault on");
    // minimum gap with dead time 0
    dead = 6'd0;
    pwm = 2'b00;
    cyc(2); chk(0, 0, "R9 minimum gap");
    cyc(1); chk(0, 1, "R9 gap of one");
    // open code keeps low side without zero current
    pwm = 2'b11;
    cyc(3); chk(0, 1, "R4 open keeps low");
    // random phase
    for (int s = 0; s < 400; s++) begin
      int r, len;
      r = $urandom_range(0, 9);
      pwm = (r < 4) ? 2'b00 : (r < 8) ? 2'b01 : (r == 8) ? 2'b10 : 2'b11;
      if ($urandom_range(0, 7) == 0) dead = 6'($urandom_range(0, 7));
      len = $urandom_range(1, 12);
      for (int c = 0; c < len; c++) begin
        zc    = ($urandom_range(0, 5) == 0);
        en    = ($urandom_range(0, 39) != 0);
        flt   = ($urandom_range(0, 79) == 0);
        ls_en = ($urandom_range(0, 9) != 0);
        cyc(1);
      end
    end
    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule